// File: doc/BRIEF.md
# Multi-context load-locked / store-conditional reservation monitor

This block arbitrates atomic read-modify-write sequences for several hardware thread contexts that share one physical memory. A context opens a reservation with a locked read. It then tries to close the reservation with a store-conditional. The block tells the requester whether the conditional store succeeded and whether the write may go on to memory. Every write that reaches memory cancels any reservation on the same 16-byte granule, in every context, including the context that issued the write.

The block takes one request per cycle. A request carries a context id, a physical address, a read/write bit, a locked bit and an uncacheable bit. Every result is registered and appears on the cycle after the request. Each context keeps a count of its consecutive failed store-conditionals. Each time that count reaches another whole multiple of a fixed period, the block emits a one-cycle warning pulse tagged with the context id, so a livelock can be spotted.

Top module: `llsc_monitor`

## Requirements
- R1: After reset all reservations are invalid and all outputs are 0. A cacheable store-conditional issued before any locked read fails with result code 0 and no write permission.
- R2: A locked read (write=0, locked=1) records the address granule (address bits above bit 3) and sets the valid flag for its context. A plain read (locked=0) changes no reservation state and drives no output.
- R3: A cacheable store-conditional succeeds when its context's flag is set and the stored granule equals the store address with bits [3:0] ignored. It then returns result code 1 with sc_valid_o=1 and wr_permit_o=1.
- R4: A failing cacheable store-conditional returns the context's flag as sampled (0 when no reservation exists, 1 when a reservation exists on another granule) and gives no write permission. It also clears that context's flag.
- R5: An uncacheable store-conditional (uncached=1) returns result code 2 with write permission, whatever the reservation state.
- R6: Every write that proceeds (plain write, successful store-conditional or uncacheable store-conditional) clears, in the same cycle, the flag of every context whose granule matches the write address, the issuer included. Contexts on other granules keep their reservations.
- R7: A plain write (write=1, locked=0) gives write permission with sc_valid_o=0.
- R8: Each context counts its consecutive failed store-conditionals. warn_o pulses for one cycle, with warn_ctx_o set to that context, whenever the count reaches a nonzero multiple of WARN_PERIOD. A successful or uncacheable store-conditional from that context restarts its count at 0. Contexts count independently.
- R9: Every output reflects the request of the previous cycle only. On the cycle after an idle cycle, sc_valid_o, wr_permit_o and warn_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_ctx_i | input | CTX_W | Issuing context id |
| req_addr_i | input | ADDR_W | Physical address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_locked_i | input | 1 | Locked read or store-conditional |
| req_uncached_i | input | 1 | Uncacheable access |
| sc_valid_o | output | 1 | Store-conditional result valid |
| sc_result_o | output | 2 | 0 fail, 1 success, 2 uncacheable |
| wr_permit_o | output | 1 | Write may proceed to memory |
| warn_o | output | 1 | Livelock warning pulse |
| warn_ctx_o | output | CTX_W | Context that raised the warning |

## Verification
The bench aims at a store-conditional whose granule differs only in bits [3:0]. A design that compared full addresses would fail that store where it should succeed. It also aims at a reservation on a different granule: a design that returned 0 there, instead of the sampled flag of 1, would disagree with the model. One plain write hits three reservations while a fourth, on another granule, is left alone; a design that cleared only the issuer or only one match would let a later store-conditional succeed wrongly. The bench repeats failures past several warning periods, with resets of the count and two contexts failing in turn. A design that shared the counter between contexts, or did not restart it on success, would put the warning pulses on the wrong cycles.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_OK       = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/llsc_fail_phase.sv
module llsc_fail_phase #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic restart_i,
  output logic warn_o
);
  localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(WARN_PERIOD - 1);

  logic [PH_W-1:0] phase_q;

  // phase = consecutive failures modulo the period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (fail_i)    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign warn_o = fail_i && (phase_q == LAST);

  a_r8_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_o && !restart_i) |=> (phase_q == '0));
endmodule

// File: rtl/llsc_ctx_slot.sv
module llsc_ctx_slot #(
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      set_i,
  input  logic                      snoop_i,
  input  logic [ADDR_W-GRAN_BITS-1:0] gran_i,
  input  logic                      fail_i,
  input  logic                      restart_i,
  output logic                      flag_o,
  output logic                      hit_o,
  output logic                      warn_o
);
  logic [ADDR_W-GRAN_BITS-1:0] gran_q;
  logic                        flag_q;

  assign hit_o  = (gran_q == gran_i);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gran_q <= '0;
      flag_q <= 1'b0;
    end else if (set_i) begin
      gran_q <= gran_i;
      flag_q <= 1'b1;
    end else if (fail_i || (snoop_i && hit_o)) begin
      flag_q <= 1'b0;
    end
  end

  llsc_fail_phase #(.WARN_PERIOD(WARN_PERIOD)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fail_i   (fail_i),
    .restart_i(restart_i),
    .warn_o   (warn_o)
  );

  a_r2_set_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r6_snoop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_i && hit_o && !set_i) |=> !flag_o);
  a_r4_fail_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_locked_i,
  input  logic              req_uncached_i,
  output logic              sc_valid_o,
  output logic [1:0]        sc_result_o,
  output logic              wr_permit_o,
  output logic              warn_o,
  output logic [CTX_W-1:0]  warn_ctx_o
);
  localparam int GW = ADDR_W - GRAN_BITS;

  logic [NUM_CTX-1:0] flag_vec, hit_vec, warn_vec;
  logic [GW-1:0]      gran;
  logic               unused_low;
  logic               rd_lock, wr, sc, sc_unc, sc_cache, sel_ok, sc_fail, sc_pass, permit;
  sc_code_e           code;

  assign gran       = req_addr_i[ADDR_W-1:GRAN_BITS];
  assign unused_low = ^req_addr_i[GRAN_BITS-1:0];

  assign rd_lock  = req_valid_i && !req_write_i && req_locked_i;
  assign wr       = req_valid_i && req_write_i;
  assign sc       = wr && req_locked_i;
  assign sc_unc   = sc && req_uncached_i;
  assign sc_cache = sc && !req_uncached_i;
  assign sel_ok   = flag_vec[req_ctx_i] && hit_vec[req_ctx_i];
  assign sc_fail  = sc_cache && !sel_ok;
  assign sc_pass  = sc_unc || (sc_cache && sel_ok);
  assign permit   = wr && !sc_fail;

  always_comb begin
    if (sc_unc)                  code = SC_UNCACHED;
    else if (flag_vec[req_ctx_i]) code = SC_OK;
    else                         code = SC_FAIL;
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    logic is_me;
    assign is_me = (req_ctx_i == CTX_W'(i));
    llsc_ctx_slot #(
      .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .WARN_PERIOD(WARN_PERIOD)
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (rd_lock && is_me),
      .snoop_i  (permit),
      .gran_i   (gran),
      .fail_i   (sc_fail && is_me),
      .restart_i(sc_pass && is_me),
      .flag_o   (flag_vec[i]),
      .hit_o    (hit_vec[i]),
      .warn_o   (warn_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_valid_o  <= 1'b0;
      sc_result_o <= '0;
      wr_permit_o <= 1'b0;
      warn_o      <= 1'b0;
      warn_ctx_o  <= '0;
    end else begin
      sc_valid_o  <= sc;
      sc_result_o <= sc ? code : SC_FAIL;
      wr_permit_o <= permit;
      warn_o      <= |warn_vec;
      warn_ctx_o  <= req_ctx_i;
    end
  end

  a_r5_uncached_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_unc |=> (sc_result_o == 2'd2) && wr_permit_o);
  a_r4_fail_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_cache && !flag_vec[req_ctx_i]) |=> !wr_permit_o && (sc_result_o == 2'd0));
  a_r9_read_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || !req_write_i) |=> !wr_permit_o && !sc_valid_o);
  a_r8_warn_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> $past(sc_cache));
  a_r8_one_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(warn_vec));
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int NC = 4;
  localparam int AW = 32;
  localparam int PER = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
  logic [1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic sc_valid, wr_permit, warn;
  logic [1:0] sc_result, warn_ctx;

  always #2 clk = ~clk;

  llsc_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(PER)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ctx_i(req_ctx),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_locked_i(req_locked),
    .req_uncached_i(req_uncached), .sc_valid_o(sc_valid), .sc_result_o(sc_result),
    .wr_permit_o(wr_permit), .warn_o(warn), .warn_ctx_o(warn_ctx));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [6:0] exp_q[$];  // {sc_valid, result[1:0], permit, warn, warn_ctx[1:0]}
  string      tag_q[$];

  // reference model
  bit          m_flag[NC];
  logic [27:0] m_gran[NC];
  int          m_fail[NC];

  task automatic step(input int ctx, input logic [AW-1:0] a, input bit v, input bit w,
                      input bit lk, input bit unc, input string tag);
    bit sv = 0, pm = 0, wn = 0;
    logic [1:0] res = 2'd0;
    @(negedge clk);
    req_valid = v; req_ctx = 2'(ctx); req_addr = a;
    req_write = w; req_locked = lk; req_uncached = unc;
    if (v && !w && lk) begin
      m_flag[ctx] = 1; m_gran[ctx] = a[31:4];
    end else if (v && w) begin
      if (lk) sv = 1;
      if (lk && unc) begin
        res = 2'd2; pm = 1; m_fail[ctx] = 0;
      end else if (lk) begin
        res = {1'b0, m_flag[ctx]};
        if (m_flag[ctx] && m_gran[ctx] == a[31:4]) begin
          pm = 1; m_fail[ctx] = 0;
        end else begin
          m_flag[ctx] = 0; m_fail[ctx]++;
          wn = (m_fail[ctx] % PER) == 0;
        end
      end else pm = 1;
      if (pm) for (int i = 0; i < NC; i++) if (m_gran[i] == a[31:4]) m_flag[i] = 0;
    end
    exp_q.push_back({sv, res, pm, wn, 2'(ctx)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e, act;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        act = {sc_valid, sc_result, wr_permit, warn, warn_ctx};
        if (!e[2]) begin e[1:0] = 2'b00; act[1:0] = 2'b00; end
        checks++;
        if (act !== e) begin
          fails++;
          $display("FAIL %s: got sv=%b res=%0d pm=%b wn=%b wctx=%0d, exp sv=%b res=%0d pm=%b wn=%b wctx=%0d",
                   t, act[6], act[5:4], act[3], act[2], act[1:0], e[6], e[5:4], e[3], e[2], e[1:0]);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_flag[i] = 0; m_gran[i] = '0; m_fail[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if ({sc_valid, sc_result, wr_permit, warn} !== 5'b0) begin
      fails++; $display("FAIL R1 reset outputs got %b exp 00000", {sc_valid, sc_result, wr_permit, warn});
    end
    rst_ni = 1'b1;
    step(0, 32'h100, 1, 1, 1, 0, "R1 sc before any reservation");
    step(0, 32'h100, 1, 0, 1, 0, "R2 locked read");
    step(0, 32'h999, 1, 0, 0, 0, "R2 plain read quiet");
    step(0, 32'h10C, 1, 1, 1, 0, "R3 sc success low bits ignored");
    step(0, 32'h100, 1, 1, 1, 0, "R6 own success cleared flag");
    step(1, 32'h200, 1, 0, 1, 0, "R2 locked read ctx1");
    step(1, 32'h210, 1, 1, 1, 0, "R4 other granule returns 1");
    step(1, 32'h200, 1, 1, 1, 0, "R4 flag cleared after fail");
    idle("R9 idle after request");
    step(0, 32'h300, 1, 0, 1, 0, "R2 ll ctx0");
    step(1, 32'h304, 1, 0, 1, 0, "R2 ll ctx1");
    step(2, 32'h30F, 1, 0, 1, 0, "R2 ll ctx2");
    step(3, 32'h400, 1, 0, 1, 0, "R2 ll ctx3");
    step(3, 32'h308, 1, 1, 0, 0, "R7 plain write permit");
    step(3, 32'h400, 1, 1, 1, 0, "R6 unmatched ctx kept");
    step(2, 32'h30F, 1, 1, 1, 0, "R6 matched ctx2 cleared");
    step(0, 32'h300, 1, 1, 1, 0, "R6 matched ctx0 cleared");
    step(1, 32'h50, 1, 1, 1, 1, "R5 uncached sc code 2");
    step(2, 32'h500, 1, 0, 1, 0, "R2 ll ctx2");
    step(0, 32'h500, 1, 1, 1, 1, "R5 uncached sc snoops");
    step(2, 32'h500, 1, 1, 1, 0, "R6 cleared by uncached sc");
    for (int k = 0; k < 20; k++) step(2, 32'h600, 1, 1, 1, 0, "R8 repeated failures");
    step(2, 32'h600, 1, 1, 1, 1, "R8 uncached restarts count");
    for (int k = 0; k < 10; k++) begin
      step(2, 32'h600, 1, 1, 1, 0, "R8 count restarted");
      step(3, 32'h700, 1, 1, 1, 0, "R8 independent contexts");
    end
    step(3, 32'h700, 1, 0, 1, 0, "R2 ll ctx3");
    step(3, 32'h700, 1, 1, 1, 0, "R8 success restarts count");
    for (int k = 0; k < 9; k++) step(3, 32'h700, 1, 1, 1, 0, "R8 after success restart");
    idle("R9 idle");
    idle("R9 idle");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule